// File: doc/BRIEF.md
# Periodic Tick Timer with Fractional Period Correction

This block is a 32-bit up-counter that advances once per pulse of a slow timebase enable (nominally a 32.768 kHz strobe). It is used to produce a periodic tick interrupt for an operating system. Software sets a start value so that the counter reaches all-ones after the wanted number of slow-clock counts. On overflow the counter either restarts from that value or halts.

When the tick rate does not divide the slow clock evenly, a signed accumulator corrects the drift. At each reload it decides whether the coming period gets one extra count. The long-run average period is then exact. For a 1 kHz tick, a start value of all-ones minus 31, with step words +232000 and −768000, gives exactly 768 extra counts in every 1000 periods.

A sticky status word records match, overflow and capture events and is cleared by writing ones. The interrupt line follows the overflow flag, gated by an enable bit.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The counter rises by one on each clock cycle in which `tickEn` is high and the run bit (control bit 0) is set. In every other cycle, including after run is cleared, it keeps its value.
- R3: A counting step from all-ones with auto-reload (control bit 1) clear sets the counter to zero and clears the run bit. The counter then stays at zero while `tickEn` continues.
- R4: A counting step from all-ones with auto-reload set loads the counter with the start value (address 1). When the period is stretched, it loads the start value minus one instead.
- R5: A signed accumulator is cleared whenever the run bit changes from 0 to 1. At each auto-reload overflow:
  - if the accumulator is negative, the next period is stretched and the positive word (address 4) is added;
  - otherwise the negative word (address 5) is added.
  - With start value 0xFFFFFFE0, words 232000 and −768000, and a counter started at 0xFFFFFFE0, the counter reads 0xFFFFFFFF after 32766 steps and 0xFFFFFFDF after 32767 steps.
- R6: The status word (address 7) holds match in bit 0, overflow in bit 1 and capture in bit 2. Writing a 1 clears a bit and writing a 0 leaves it. A setting event in the same cycle as the clear wins.
- R7: A write to the counter (address 2) takes effect at the next edge and overrides a step in that cycle. A write to the start value leaves the running count untouched and is used only from the next reload.
- R8: `irq` is high exactly when status bit 1 is set and interrupt-enable bit 0 (address 6) is set.
- R9: The match flag sets on a counting step whose new count equals the match value (address 3), but only while match enable (control bit 2) is set.
- R10: A one-cycle pulse on `capEvent` sets status bit 2.
- R11: Register map: 0 control, 1 start value, 2 counter, 3 match value, 4 positive word, 5 negative word, 6 interrupt enable, 7 status. `busRData` returns the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Slow timebase enable, one cycle per count |
| capEvent | input | 1 | Capture event pulse that sets the capture flag |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 3 | Register word address |
| busWData | input | 32 | Register write data |
| busRData | output | 32 | Read data for the addressed register |
| irq | output | 1 | Tick interrupt |

## Verification
The assertions assume that the positive word is non-negative and the negative word is negative. Under that assumption the accumulator stays in a bounded signed range and never wraps. They also assume that `tickEn` is a plain level sampled once per clock, with no relation to bus writes.

The stimulus programs the step words only with the run bit clear and only with values of those signs. It deliberately lines up writes with overflow cycles so that the priority rules are exercised. It holds `tickEn` high for the long drift run and toggles it for the short runs.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
package tick_timer_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_LOAD   = 3'd1,
    REG_COUNT  = 3'd2,
    REG_MATCH  = 3'd3,
    REG_POSINC = 3'd4,
    REG_NEGINC = 3'd5,
    REG_IRQEN  = 3'd6,
    REG_STATUS = 3'd7
  } regAddr_e;

  localparam int FLAG_MATCH = 0;
  localparam int FLAG_OVF   = 1;
  localparam int FLAG_CAP   = 2;
  localparam int N_FLAGS    = 3;

  localparam int CTRL_RUN = 0;
  localparam int CTRL_AR  = 1;
  localparam int CTRL_MEN = 2;

  // strobes and mode bits handed from control to datapath each cycle
  typedef struct packed {
    logic step;
    logic countWr;
    logic accClr;
    logic autoReload;
    logic matchEn;
  } dpStrobe_t;
endpackage

// File: rtl/tick_datapath.sv
`timescale 1ns/1ps
module tick_datapath
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] wrData,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] matchVal,
  input  logic [CNT_W-1:0] posInc,
  input  logic [CNT_W-1:0] negInc,
  output logic [CNT_W-1:0] count,
  output logic             ovfEvt,
  output logic             matchEvt
);
  localparam int ACC_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] countQ, nextCount;
  logic signed [ACC_W-1:0] accQ, accNext, posExt, negExt;
  logic stretch, atTop;

  assign posExt  = {posInc[CNT_W-1], posInc};
  assign negExt  = {negInc[CNT_W-1], negInc};
  assign stretch = accQ[ACC_W-1];
  assign atTop   = (countQ == CNT_MAX);

  always_comb begin
    nextCount = countQ;
    ovfEvt    = 1'b0;
    if (strobe.countWr) begin
      nextCount = wrData;
    end else if (strobe.step) begin
      if (atTop) begin
        ovfEvt    = 1'b1;
        nextCount = strobe.autoReload ? (loadVal - CNT_W'(stretch)) : '0;
      end else begin
        nextCount = countQ + 1'b1;
      end
    end
  end

  assign matchEvt = strobe.step & ~strobe.countWr & strobe.matchEn &
                    (nextCount == matchVal);

  always_comb begin
    accNext = accQ;
    if (strobe.accClr)
      accNext = '0;
    else if (ovfEvt && strobe.autoReload)
      accNext = accQ + (stretch ? posExt : negExt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      accQ   <= '0;
    end else begin
      countQ <= nextCount;
      accQ   <= accNext;
    end
  end

  assign count = countQ;

  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step && !strobe.countWr && !atTop |=> countQ == $past(countQ) + 1'b1);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.step && !strobe.countWr |=> $stable(countQ));
  // R7
  count_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.countWr |=> countQ == $past(wrData));
  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step && !strobe.countWr && atTop && strobe.autoReload |=>
      (countQ == $past(loadVal)) || (countQ == $past(loadVal) - 1'b1));
  // R5
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accClr |=> accQ == '0);
endmodule

// File: rtl/tick_ctrl.sv
`timescale 1ns/1ps
module tick_ctrl
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              capEvent,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWData,
  input  logic [CNT_W-1:0]  count,
  input  logic              ovfEvt,
  input  logic              matchEvt,
  output dpStrobe_t         strobe,
  output logic [CNT_W-1:0]  loadVal,
  output logic [CNT_W-1:0]  matchVal,
  output logic [CNT_W-1:0]  posInc,
  output logic [CNT_W-1:0]  negInc,
  output logic [CNT_W-1:0]  busRData,
  output logic              irq
);
  regAddr_e addr;
  logic runQ, arQ, menQ, irqEnQ;
  logic [N_FLAGS-1:0] flagsQ, flagEvt, flagClr;
  logic wrCtrl, wrStatus;

  assign addr     = regAddr_e'(busAddr);
  assign wrCtrl   = busWr && (addr == REG_CTRL);
  assign wrStatus = busWr && (addr == REG_STATUS);

  assign strobe.step       = tickEn & runQ;
  assign strobe.countWr    = busWr && (addr == REG_COUNT);
  assign strobe.accClr     = wrCtrl & busWData[CTRL_RUN] & ~runQ;
  assign strobe.autoReload = arQ;
  assign strobe.matchEn    = menQ;

  always_comb begin
    flagEvt            = '0;
    flagEvt[FLAG_MATCH] = matchEvt;
    flagEvt[FLAG_OVF]   = ovfEvt;
    flagEvt[FLAG_CAP]   = capEvent;
    flagClr = wrStatus ? busWData[N_FLAGS-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      arQ      <= 1'b0;
      menQ     <= 1'b0;
      irqEnQ   <= 1'b0;
      flagsQ   <= '0;
      loadVal  <= '0;
      matchVal <= '0;
      posInc   <= '0;
      negInc   <= '0;
    end else begin
      if (wrCtrl) begin
        runQ <= busWData[CTRL_RUN];
        arQ  <= busWData[CTRL_AR];
        menQ <= busWData[CTRL_MEN];
      end else if (ovfEvt && !arQ) begin
        runQ <= 1'b0;
      end
      if (busWr && addr == REG_LOAD)   loadVal  <= busWData;
      if (busWr && addr == REG_MATCH)  matchVal <= busWData;
      if (busWr && addr == REG_POSINC) posInc   <= busWData;
      if (busWr && addr == REG_NEGINC) negInc   <= busWData;
      if (busWr && addr == REG_IRQEN)  irqEnQ   <= busWData[0];
      flagsQ <= (flagsQ & ~flagClr) | flagEvt;
    end
  end

  always_comb begin
    case (addr)
      REG_CTRL:   busRData = CNT_W'({menQ, arQ, runQ});
      REG_LOAD:   busRData = loadVal;
      REG_COUNT:  busRData = count;
      REG_MATCH:  busRData = matchVal;
      REG_POSINC: busRData = posInc;
      REG_NEGINC: busRData = negInc;
      REG_IRQEN:  busRData = CNT_W'(irqEnQ);
      REG_STATUS: busRData = CNT_W'(flagsQ);
      default:    busRData = '0;
    endcase
  end

  assign irq = flagsQ[FLAG_OVF] & irqEnQ;

  // R3
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvt && !arQ && !wrCtrl |=> !runQ);
  // R6
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvt |=> flagsQ[FLAG_OVF]);
  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStatus && busWData[FLAG_OVF] && !ovfEvt |=> !flagsQ[FLAG_OVF]);
  // R10
  cap_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    capEvent |=> flagsQ[FLAG_CAP]);
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              capEvent,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWData,
  output logic [CNT_W-1:0]  busRData,
  output logic              irq
);
  dpStrobe_t strobe;
  logic [CNT_W-1:0] loadVal, matchVal, posInc, negInc, count;
  logic ovfEvt, matchEvt;

  tick_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .capEvent(capEvent),
    .busWr(busWr), .busAddr(busAddr), .busWData(busWData),
    .count(count), .ovfEvt(ovfEvt), .matchEvt(matchEvt),
    .strobe(strobe), .loadVal(loadVal), .matchVal(matchVal),
    .posInc(posInc), .negInc(negInc), .busRData(busRData), .irq(irq)
  );

  tick_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWData),
    .loadVal(loadVal), .matchVal(matchVal), .posInc(posInc),
    .negInc(negInc), .count(count), .ovfEvt(ovfEvt), .matchEvt(matchEvt)
  );
endmodule

// File: tb/tick_timer_bench.sv
`timescale 1ns/1ps
module tick_timer_bench;
  import tick_timer_pkg::*;

  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0, capEvent = 1'b0, busWr = 1'b0;
  logic [2:0]  busAddr = REG_COUNT;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        irq;

  tick_timer u_tick_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .capEvent(capEvent),
    .busWr(busWr), .busAddr(busAddr), .busWData(busWData),
    .busRData(busRData), .irq(irq)
  );

  always #4 clk = ~clk;

  int nVec = 0, nFail = 0;

  // behavioural reference state
  logic [31:0] mCount, mLoad, mMatch, mPos, mNeg;
  longint mAcc;
  bit mRun, mAr, mMen, mIrqEn;
  bit [2:0] mFlags;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mRead(logic [2:0] a);
    case (a)
      3'd0: return {29'd0, mMen, mAr, mRun};
      3'd1: return mLoad;
      3'd2: return mCount;
      3'd3: return mMatch;
      3'd4: return mPos;
      3'd5: return mNeg;
      3'd6: return {31'd0, mIrqEn};
      default: return {29'd0, mFlags};
    endcase
  endfunction

  function automatic string tagFor(logic [2:0] a);
    if (a == 3'd2) return "R2";
    if (a == 3'd7) return "R6";
    return "R11";
  endfunction

  task automatic modelStep();
    bit step, ovf, mev, st;
    logic [31:0] nc;
    logic [2:0] clr;
    step = tickEn && mRun;
    ovf = 0; mev = 0;
    nc = mCount;
    if (busWr && busAddr == 3'd2) nc = busWData;
    else if (step) begin
      if (mCount == 32'hFFFF_FFFF) begin
        ovf = 1;
        if (mAr) begin
          st = (mAcc < 0);
          mAcc = mAcc + (st ? longint'($signed(mPos)) : longint'($signed(mNeg)));
          nc = mLoad - (st ? 32'd1 : 32'd0);
        end else nc = 32'd0;
      end else nc = mCount + 32'd1;
      mev = mMen && (nc == mMatch);
    end
    mCount = nc;
    clr = (busWr && busAddr == 3'd7) ? busWData[2:0] : 3'd0;
    mFlags = (mFlags & ~clr) | {capEvent, ovf, mev};
    if (busWr && busAddr == 3'd0) begin
      if (busWData[0] && !mRun) mAcc = 0;
      mRun = busWData[0]; mAr = busWData[1]; mMen = busWData[2];
    end else if (ovf && !mAr) mRun = 0;
    if (busWr && busAddr == 3'd1) mLoad  = busWData;
    if (busWr && busAddr == 3'd3) mMatch = busWData;
    if (busWr && busAddr == 3'd4) mPos   = busWData;
    if (busWr && busAddr == 3'd5) mNeg   = busWData;
    if (busWr && busAddr == 3'd6) mIrqEn = busWData[0];
  endtask

  task automatic cycle();
    modelStep();
    @(posedge clk);
    #1;
    check(busRData === mRead(busAddr), tagFor(busAddr), busRData, mRead(busAddr));
    check(irq === (mFlags[1] & mIrqEn), "R8", {31'd0, irq}, {31'd0, mFlags[1] & mIrqEn});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWData = d;
    cycle();
    busWr = 1'b0; busAddr = REG_COUNT; busWData = '0;
  endtask

  task automatic expectReg(logic [2:0] a, logic [31:0] exp, string tag);
    busAddr = a;
    #1;
    check(busRData === exp, tag, busRData, exp);
    busAddr = REG_COUNT;
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL R2 watchdog expired: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    mCount = 0; mLoad = 0; mMatch = 0; mPos = 0; mNeg = 0; mAcc = 0;
    mRun = 0; mAr = 0; mMen = 0; mIrqEn = 0; mFlags = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state of every register and the interrupt
    for (int a = 0; a < 8; a++) expectReg(3'(a), 32'd0, "R1");
    check(irq === 1'b0, "R1", {31'd0, irq}, 32'd0);

    // R11 register readback
    wr(REG_LOAD, 32'h1234_5678);
    wr(REG_MATCH, 32'hFFFF_0000);
    wr(REG_IRQEN, 32'd1);
    expectReg(REG_LOAD, 32'h1234_5678, "R11");
    expectReg(REG_IRQEN, 32'd1, "R11");

    // R2 gapped counting, then freeze
    wr(REG_COUNT, 32'd100);
    wr(REG_CTRL, 32'd1);
    for (int i = 0; i < 20; i++) begin
      tickEn = (i % 2 == 0);
      cycle();
    end
    expectReg(REG_COUNT, 32'd110, "R2");
    tickEn = 1'b0;
    wr(REG_CTRL, 32'd0);
    tickEn = 1'b1;
    idle(5);
    expectReg(REG_COUNT, 32'd110, "R2");

    // R7 counter write wins over a step
    wr(REG_CTRL, 32'd1);
    wr(REG_COUNT, 32'd500);
    expectReg(REG_COUNT, 32'd500, "R7");

    // R3 one-shot overflow, R8 interrupt
    tickEn = 1'b0;
    wr(REG_CTRL, 32'd0);
    wr(REG_COUNT, 32'hFFFF_FFFD);
    wr(REG_CTRL, 32'd1);
    tickEn = 1'b1;
    idle(3);
    expectReg(REG_COUNT, 32'd0, "R3");
    expectReg(REG_CTRL, 32'd0, "R3");
    check(irq === 1'b1, "R8", {31'd0, irq}, 32'd1);
    idle(4);
    expectReg(REG_COUNT, 32'd0, "R3");

    // R6 write-one-to-clear, R10 capture, zero write keeps flags
    wr(REG_STATUS, 32'd2);
    check(irq === 1'b0, "R8", {31'd0, irq}, 32'd0);
    capEvent = 1'b1; cycle(); capEvent = 1'b0;
    wr(REG_STATUS, 32'd0);
    expectReg(REG_STATUS, 32'd4, "R10");

    // R6 overflow event beats a same-cycle clear
    tickEn = 1'b0;
    wr(REG_COUNT, 32'hFFFF_FFFF);
    wr(REG_CTRL, 32'd1);
    tickEn = 1'b1;
    wr(REG_STATUS, 32'd7);
    expectReg(REG_STATUS, 32'd2, "R6");
    wr(REG_STATUS, 32'd7);

    // R9 match flag with and without enable
    tickEn = 1'b0;
    wr(REG_MATCH, 32'h20);
    wr(REG_COUNT, 32'h1E);
    wr(REG_CTRL, 32'd5);
    tickEn = 1'b1;
    cycle();
    expectReg(REG_STATUS, 32'd0, "R9");
    cycle();
    expectReg(REG_STATUS, 32'd1, "R9");
    tickEn = 1'b0;
    wr(REG_STATUS, 32'd1);
    wr(REG_COUNT, 32'h1E);
    wr(REG_CTRL, 32'd1);
    tickEn = 1'b1;
    idle(4);
    expectReg(REG_STATUS, 32'd0, "R9");

    // R4 reload, R7 deferred start value, R5 stretched period
    tickEn = 1'b0;
    wr(REG_CTRL, 32'd0);
    wr(REG_LOAD, 32'hFFFF_FF00);
    wr(REG_POSINC, 32'd232000);
    wr(REG_NEGINC, -32'sd768000);
    wr(REG_COUNT, 32'hFFFF_FFFE);
    wr(REG_CTRL, 32'd3);
    tickEn = 1'b1;
    idle(2);
    expectReg(REG_COUNT, 32'hFFFF_FF00, "R4");
    wr(REG_LOAD, 32'hFFFF_FFF0);
    expectReg(REG_COUNT, 32'hFFFF_FF01, "R7");
    wr(REG_COUNT, 32'hFFFF_FFFF);
    cycle();
    expectReg(REG_COUNT, 32'hFFFF_FFEF, "R5");

    // R5 long-run average over 1000 periods
    tickEn = 1'b0;
    wr(REG_CTRL, 32'd0);
    wr(REG_STATUS, 32'd7);
    wr(REG_LOAD, 32'hFFFF_FFE0);
    wr(REG_COUNT, 32'hFFFF_FFE0);
    wr(REG_CTRL, 32'd3);
    tickEn = 1'b1;
    idle(32766);
    expectReg(REG_COUNT, 32'hFFFF_FFFF, "R5");
    cycle();
    expectReg(REG_COUNT, 32'hFFFF_FFDF, "R5");
    tickEn = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule